// File: doc/BRIEF.md
# DMA Burst Boundary Splitter

This block sits in the address path of one DMA channel. A requested burst, given as a start address, a beat count, a beat width and an increment flag, is turned into one or two transaction descriptors. The split ensures that no incrementing burst crosses an address boundary aligned to the total burst size in bytes, which is the beat count times the beat width. Some slaves, memories in particular, refuse bursts that cross such a boundary, so the channel relies on this split before it issues anything on the bus.

A burst is launched with a one-cycle start strobe while the block is idle. Descriptors leave on a valid/ready handshake. The head part always comes first. When a done pulse appears, the last descriptor of the request has been taken. Fixed-address bursts, such as those aimed at a peripheral data register, are never split. Start addresses are assumed to be aligned to the beat width. The beat count is one of 1, 4, 8, 16, 32, 64, 128 or 256.

Top module: `burst_splitter`

## Requirements
- R1: After reset, desc_valid_o, done_o and busy_o are all low.
- R2: An incrementing burst whose start address is a multiple of span = len_i × width is issued as a single descriptor, carrying the start address and len_i beats.
- R3: An incrementing burst whose start address is not a multiple of span is split into two descriptors. The head is at the start address and carries (B − addr)/width beats, where B is the next multiple of span above the address. The tail is at B and carries the remaining beats. For example, 16 beats of 4 bytes from 0x0C000024 give 7 beats at 0x0C000024, then 9 beats at 0x0C000040.
- R4: With incr_i low, the burst is issued as one descriptor at the start address with all len_i beats, whatever its alignment.
- R5: size_i encodes the beat width as follows: 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. The boundary span scales with this width.
- R6: While desc_valid_o is high and desc_ready_i is low, desc_valid_o stays high and desc_addr_o and desc_beats_o stay unchanged.
- R7: The tail descriptor is presented only after the head has been accepted, in the cycle that follows that acceptance.
- R8: done_o is high for exactly one cycle, in the cycle after the final descriptor is accepted. In that same cycle busy_o and desc_valid_o are low.
- R9: start_i is ignored while busy_o is high. addr_i, len_i, size_i and incr_i are sampled only when a start is accepted.
- R10: The boundary is computed modulo 2^ADDR_W, so a burst that crosses the top of the address space has its tail at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a burst request |
| addr_i | input | ADDR_W | Start address of the burst |
| len_i | input | LEN_W | Beat count of the burst |
| size_i | input | 2 | Beat width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| incr_i | input | 1 | Address increment enable |
| busy_o | output | 1 | High while the request is being issued |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_ready_i | input | 1 | Descriptor accepted by the consumer |
| desc_addr_o | output | ADDR_W | Descriptor start address |
| desc_beats_o | output | LEN_W | Descriptor beat count |
| done_o | output | 1 | One-cycle pulse after the last descriptor is accepted |

## Verification
Two situations are hard to reach from the ports. The first is a second start arriving while the head descriptor is held by back-pressure. The second is a burst that straddles the top of the address space. The stimulus handles the first by stalling the ready signal for random spans and, on chosen requests, pulsing start with unrelated inputs during the stall. Right after each accepted start it also scrambles all request inputs. Directed requests at the very top of memory and at the largest length, combined with random width-aligned addresses across all lengths and widths, drive the boundary arithmetic through every span.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_TAIL = 2'd2
  } split_state_e;

  localparam int unsigned SIZE_W = 2;
endpackage

// File: rtl/boundary_calc.sv
module boundary_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 9
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [LEN_W-1:0]                len_i,
  input  logic [splitter_pkg::SIZE_W-1:0] size_i,
  input  logic                            incr_i,
  output logic                            split_o,
  output logic [LEN_W-1:0]                head_beats_o,
  output logic [LEN_W-1:0]                tail_beats_o,
  output logic [ADDR_W-1:0]               tail_addr_o
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] span, mask, bound, head_bytes, head_full, addr_ext, len_ext;

  always_comb begin
    addr_ext   = {1'b0, addr_i};
    len_ext    = EXT_W'(len_i);
    span       = len_ext << size_i;
    mask       = span - EXT_W'(1);
    // next span-aligned address strictly above addr
    bound      = (addr_ext | mask) + EXT_W'(1);
    head_bytes = bound - addr_ext;
    head_full  = head_bytes >> size_i;
    split_o    = incr_i && (head_full < len_ext);
    head_beats_o = split_o ? head_full[LEN_W-1:0] : len_i;
    tail_beats_o = split_o ? (len_i - head_full[LEN_W-1:0]) : '0;
    tail_addr_o  = bound[ADDR_W-1:0];
  end
endmodule

// File: rtl/split_sequencer.sv
module split_sequencer #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              incr_i,
  input  logic              split_i,
  input  logic [LEN_W-1:0]  head_beats_i,
  input  logic [LEN_W-1:0]  tail_beats_i,
  input  logic [ADDR_W-1:0] tail_addr_i,
  output logic              busy_o,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [LEN_W-1:0]  desc_beats_o,
  output logic              done_o
);
  import splitter_pkg::*;

  split_state_e      state_q, state_d;
  logic [ADDR_W-1:0] head_addr_q, tail_addr_q;
  logic [LEN_W-1:0]  head_beats_q, tail_beats_q, len_q;
  logic              split_q, incr_q, done_q;
  logic              accept, take, last_take;

  assign accept    = start_i && (state_q == ST_IDLE);
  assign take      = desc_valid_o && desc_ready_i;
  assign last_take = take && ((state_q == ST_TAIL) || !split_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_HEAD;
      ST_HEAD: if (take)   state_d = split_q ? ST_TAIL : ST_IDLE;
      ST_TAIL: if (take)   state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      head_addr_q  <= '0;
      tail_addr_q  <= '0;
      head_beats_q <= '0;
      tail_beats_q <= '0;
      len_q        <= '0;
      split_q      <= 1'b0;
      incr_q       <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last_take;
      if (accept) begin
        head_addr_q  <= addr_i;
        tail_addr_q  <= tail_addr_i;
        head_beats_q <= head_beats_i;
        tail_beats_q <= tail_beats_i;
        len_q        <= len_i;
        split_q      <= split_i;
        incr_q       <= incr_i;
      end
    end
  end

  assign desc_valid_o = (state_q != ST_IDLE);
  assign busy_o       = desc_valid_o;
  assign desc_addr_o  = (state_q == ST_TAIL) ? tail_addr_q : head_addr_q;
  assign desc_beats_o = (state_q == ST_TAIL) ? tail_beats_q : head_beats_q;
  assign done_o       = done_q;

  p_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_addr_o) && $stable(desc_beats_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !desc_valid_o);

  p_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_beats_o != '0);

  p_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAIL) |-> (head_beats_q + tail_beats_q == len_q));

  p_fixed_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !incr_q |-> (state_q == ST_HEAD) && (desc_beats_o == len_q));

  p_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> (state_q != ST_TAIL));

  p_ignore_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HEAD) && !desc_ready_i && start_i |=> (state_q == ST_HEAD) && $stable(head_addr_q));
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        size_i,
  input  logic              incr_i,
  output logic              busy_o,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [LEN_W-1:0]  desc_beats_o,
  output logic              done_o
);
  logic              split;
  logic [LEN_W-1:0]  head_beats, tail_beats;
  logic [ADDR_W-1:0] tail_addr;

  boundary_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_calc (
    .addr_i       (addr_i),
    .len_i        (len_i),
    .size_i       (size_i),
    .incr_i       (incr_i),
    .split_o      (split),
    .head_beats_o (head_beats),
    .tail_beats_o (tail_beats),
    .tail_addr_o  (tail_addr)
  );

  split_sequencer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .addr_i       (addr_i),
    .len_i        (len_i),
    .incr_i       (incr_i),
    .split_i      (split),
    .head_beats_i (head_beats),
    .tail_beats_i (tail_beats),
    .tail_addr_i  (tail_addr),
    .busy_o       (busy_o),
    .desc_valid_o (desc_valid_o),
    .desc_ready_i (desc_ready_i),
    .desc_addr_o  (desc_addr_o),
    .desc_beats_o (desc_beats_o),
    .done_o       (done_o)
  );
endmodule

// File: tb/test_burst_splitter.sv
module test_burst_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        incr = 1'b0;
  logic        ready = 1'b0;
  logic [31:0] addr = '0;
  logic [8:0]  len = '0;
  logic [1:0]  size = '0;
  logic        busy, valid, done;
  logic [31:0] d_addr;
  logic [8:0]  d_beats;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  burst_splitter i_burst_splitter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
    .size_i(size), .incr_i(incr), .busy_o(busy), .desc_valid_o(valid),
    .desc_ready_i(ready), .desc_addr_o(d_addr), .desc_beats_o(d_beats), .done_o(done)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_burst(logic [31:0] a, int l, int s, bit inc, bit poke, string tag);
    longint w, span, off, room;
    longint ea[2], eb[2];
    int n;
    string t;
    w    = longint'(1) << s;
    span = longint'(l) * w;
    off  = longint'(a) % span;
    room = (span - off) / w;
    if (!inc || room >= l) begin
      n = 1; ea[0] = a; eb[0] = l; ea[1] = 0; eb[1] = 0;
    end else begin
      n = 2; ea[0] = a; eb[0] = room;
      ea[1] = (longint'(a) - off + span) & 64'hFFFF_FFFF;
      eb[1] = l - room;
    end
    t = (tag != "") ? tag : ((n == 2) ? "R3" : (inc ? "R2" : "R4"));
    @(negedge clk);
    addr = a; len = l[8:0]; size = s[1:0]; incr = inc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble inputs: must not matter after acceptance (R9)
    addr = $urandom; len = 9'($urandom_range(1, 256)); size = 2'($urandom_range(0, 2)); incr = ~inc;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    for (int k = 0; k < n; k++) begin
      int stall;
      stall = $urandom_range(0, 2);
      if (poke && k == 0 && stall == 0) stall = 1;
      for (int j = 0; j < stall; j++) begin
        chk(valid && d_addr == ea[k][31:0] && d_beats == eb[k][8:0], "R6 hold under stall",
            {d_addr, 7'd0, d_beats}, {ea[k][31:0], 7'd0, eb[k][8:0]});
        if (poke && k == 0 && j == 0) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      chk(valid == 1'b1, {t, " R7 valid"}, valid, 1);
      chk(d_addr == ea[k][31:0], {t, " addr"}, d_addr, ea[k]);
      chk(d_beats == eb[k][8:0], {t, " beats"}, d_beats, eb[k]);
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
    end
    chk(done == 1'b1, "R8 done pulse", done, 1);
    chk(!valid && !busy, "R8 R9 idle after last", {valid, busy}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 single cycle", done, 0);
    chk(!valid, "R9 no extra descriptor", valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lens[8] = '{1, 4, 8, 16, 32, 64, 128, 256};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!valid && !done && !busy, "R1 reset state", {valid, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_burst(32'h0C00_0024, 16, 2, 1'b1, 1'b0, "R3");   // 7 @ ..24, 9 @ ..40
    run_burst(32'h0000_1000, 16, 2, 1'b1, 1'b0, "R2");
    run_burst(32'h0C00_0024, 16, 2, 1'b0, 1'b0, "R4");
    run_burst(32'h0000_0003,  8, 0, 1'b1, 1'b0, "R5");   // 5 @ 3, 3 @ 8
    run_burst(32'h0000_002E, 32, 1, 1'b1, 1'b0, "R5");   // 9 @ 2E, 23 @ 40
    run_burst(32'h0000_0004, 256, 2, 1'b1, 1'b0, "R3");  // 255 + 1
    run_burst(32'hFFFF_FFF8,  4, 2, 1'b1, 1'b0, "R10");  // 2 @ top, 2 @ 0
    run_burst(32'h0000_0111,  1, 0, 1'b1, 1'b0, "R2");
    run_burst(32'h0000_0A24, 16, 2, 1'b1, 1'b1, "R9");

    for (int i = 0; i < 300; i++) begin
      int l, s;
      logic [31:0] a;
      l = lens[$urandom_range(0, 7)];
      s = $urandom_range(0, 2);
      a = $urandom;
      a = a & ~(32'((1 << s) - 1));
      run_burst(a, l, s, ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0), "");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule